// File: doc/BRIEF.md
# Multi-Channel DMA Sequencer with Completion Interrupts

This block holds the control state of several DMA channels and decides when each channel moves data. Each channel is configured with one write that loads its transfer count and a four-bit control word. A channel starts at once, or waits for a falling edge on its own external request pin, or does not start at all while chaining is selected, since loading chained descriptors is not part of this block. Active channels compete for one transfer port. A rotating arbiter shares that port among them, and each accepted transfer decrements the owning channel's count.

When a channel's count reaches zero through its final accepted transfer, the block sets that channel's done status bit. If the channel's interrupt enable is set, it also latches a completion interrupt. Pending interrupts stay set until software clears them. They are gated by a mask, and a fixed-priority encoder reports the lowest-numbered unmasked pending channel. Software may poll the done bits instead of taking interrupts.

The transfer port is valid/ready. The block raises `xfer_valid` with the granted channel on `xfer_ch`. A transfer happens on a clock edge where `xfer_valid` and `xfer_ready` are both high. While `xfer_ready` is low, the block holds `xfer_valid` and `xfer_ch` steady. The only exception is a configuration write, which may withdraw the request. The control word is laid out as bit0 enable, bit1 chaining, bit2 request mode, bit3 interrupt enable.

Top module: `dma_seq_top`

## Requirements
- R1: A write with enable=1, chaining=0 and request mode=0 and count N>0 starts the channel at once. The channel then makes exactly N accepted transfers on its channel number and sets its `done_stat` bit after the last one.
- R2: With enable=1, chaining=0 and request mode=1, the channel makes no transfer while its `dreq_n` pin stays high. It starts its sequence after a high-to-low transition of that pin, which is passed through two synchronising flip-flops before edge detection.
- R3: The final accepted transfer sets the channel's `irq_pend` bit only if interrupt enable=1. With interrupt enable=0, only `done_stat` is set.
- R4: A write of count zero produces no transfer, no pending interrupt and no done status. This holds even with enable and interrupt enable set.
- R5: A write that clears enable in mid-sequence stops the channel's transfers. It raises no interrupt and leaves the done bit clear.
- R6: An `irq_pend` bit stays set until a 1 is written to the same bit of `irq_clr`. If the clear and a new completion fall on the same edge, the bit stays set.
- R7: `irq_out` is high when any pending bit has its `irq_mask` bit at 1. `irq_vec` gives the lowest-numbered such channel, so channel 0 has the highest priority. The priority does not depend on the arbitration order.
- R8: At each accepted transfer, the grant goes to the first requesting channel after the channel granted last, in ascending circular order. After reset, the channel granted last is taken to be NCH-1.
- R9: While `xfer_valid` is high and `xfer_ready` is low, with no configuration write, `xfer_valid` stays high and `xfer_ch` stays unchanged on the next cycle.
- R10: A channel written with chaining=1 does not start and makes no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_ctrl | input | 4 | Control word: bit0 enable, bit1 chaining, bit2 request mode, bit3 interrupt enable |
| cfg_count | input | CNT_W | Transfer count loaded by the write |
| dreq_n | input | NCH | Asynchronous active-low request pins, one per channel |
| xfer_valid | output | 1 | Transfer request to the data port |
| xfer_ready | input | 1 | Data port accepts the transfer |
| xfer_ch | output | CH_W | Channel owning the current transfer |
| irq_mask | input | NCH | Interrupt mask, 1 lets the channel through |
| irq_clr | input | NCH | Write-one-to-clear for pending interrupts |
| irq_pend | output | NCH | Latched pending interrupts |
| irq_out | output | 1 | Any unmasked interrupt pending |
| irq_vec | output | CH_W | Highest-priority unmasked pending channel |
| done_stat | output | NCH | Per-channel sequence completion status |

## Verification
Two functions can fall in the same cycle: the final accepted transfer of a channel, which sets its pending bit, and a write-one-to-clear on that same bit. The bench sets this up by holding a one-transfer channel stalled with `xfer_ready` low. It then raises `xfer_ready` and the matching `irq_clr` bit for the same single cycle. After that edge the pending bit must still read 1, and a later clear on its own must bring it to 0. The scoreboard also predicts the complete rotating grant order when four channels are released by a single request edge under intermittent back-pressure.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_ARMED  = 2'd1,
    CH_ACTIVE = 2'd2
  } ch_state_e;

  typedef struct packed {
    logic irq_en;
    logic req_mode;
    logic chain;
    logic enable;
  } ch_ctrl_t;
endpackage

// File: rtl/dmaseq_sync.sv
module dmaseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_n,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din_n};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/dmaseq_chan.sv
module dmaseq_chan
  import dmaseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_hit,
  input  ch_ctrl_t         cfg_ctrl,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             req_fall,
  input  logic             xfer_fire,
  output logic             bus_req,
  output logic             done,
  output logic             irq_evt
);
  ch_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             irq_en_q;
  logic             last_beat;

  assign last_beat = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= CH_IDLE;
      cnt_q    <= '0;
      en_q     <= 1'b0;
      irq_en_q <= 1'b0;
      done     <= 1'b0;
    end else if (cfg_hit) begin
      cnt_q    <= cfg_count;
      en_q     <= cfg_ctrl.enable;
      irq_en_q <= cfg_ctrl.irq_en;
      done     <= 1'b0;
      if (cfg_ctrl.enable && !cfg_ctrl.chain) begin
        if (cfg_ctrl.req_mode)
          state_q <= CH_ARMED;
        else if (cfg_count != '0)
          state_q <= CH_ACTIVE;
        else
          state_q <= CH_IDLE;
      end else begin
        state_q <= CH_IDLE;
      end
    end else begin
      case (state_q)
        CH_ARMED: begin
          if (!en_q)
            state_q <= CH_IDLE;
          else if (req_fall)
            state_q <= (cnt_q != '0) ? CH_ACTIVE : CH_IDLE;
        end
        CH_ACTIVE: begin
          if (xfer_fire) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (last_beat) begin
              state_q <= CH_IDLE;
              done    <= 1'b1;
            end
          end
        end
        default: state_q <= CH_IDLE;
      endcase
    end
  end

  assign bus_req = (state_q == CH_ACTIVE);
  assign irq_evt = xfer_fire && bus_req && last_beat && irq_en_q && !cfg_hit;
endmodule

// File: rtl/dmaseq_arb.sv
module dmaseq_arb #(
  parameter int NCH  = 4,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  req,
  input  logic            ready,
  output logic            valid,
  output logic [CH_W-1:0] gnt_ch,
  output logic [NCH-1:0]  fire
);
  logic [CH_W-1:0] last_q;
  logic [CH_W-1:0] hold_ch_q;
  logic            hold_q;
  logic [CH_W-1:0] pick;
  logic            found;
  int              idx;

  always_comb begin
    pick  = last_q;
    found = 1'b0;
    idx   = 0;
    for (int k = 1; k <= NCH; k++) begin
      idx = (int'(last_q) + k) % NCH;
      if (!found && req[idx]) begin
        pick  = CH_W'(idx);
        found = 1'b1;
      end
    end
    if (hold_q && req[hold_ch_q]) begin
      pick  = hold_ch_q;
      found = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q    <= CH_W'(NCH - 1);
      hold_q    <= 1'b0;
      hold_ch_q <= '0;
    end else begin
      hold_q    <= found && !ready;
      hold_ch_q <= pick;
      if (found && ready)
        last_q <= pick;
    end
  end

  assign valid  = found;
  assign gnt_ch = pick;

  always_comb begin
    fire = '0;
    if (found && ready)
      fire[pick] = 1'b1;
  end
endmodule

// File: rtl/dmaseq_irq.sv
module dmaseq_irq #(
  parameter int NCH  = 4,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  set,
  input  logic [NCH-1:0]  clr,
  input  logic [NCH-1:0]  mask,
  output logic [NCH-1:0]  pend,
  output logic            irq,
  output logic [CH_W-1:0] vec
);
  logic [NCH-1:0] live;

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend <= '0;
    else
      pend <= (pend & ~clr) | set;
  end

  assign live = pend & mask;
  assign irq  = |live;

  always_comb begin
    vec = '0;
    for (int k = NCH - 1; k >= 0; k--)
      if (live[k])
        vec = CH_W'(k);
  end
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
  import dmaseq_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CH_W-1:0]  cfg_ch,
  input  logic [3:0]       cfg_ctrl,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [NCH-1:0]   dreq_n,
  output logic             xfer_valid,
  input  logic             xfer_ready,
  output logic [CH_W-1:0]  xfer_ch,
  input  logic [NCH-1:0]   irq_mask,
  input  logic [NCH-1:0]   irq_clr,
  output logic [NCH-1:0]   irq_pend,
  output logic             irq_out,
  output logic [CH_W-1:0]  irq_vec,
  output logic [NCH-1:0]   done_stat
);
  logic [NCH-1:0] ch_req;
  logic [NCH-1:0] ch_fire;
  logic [NCH-1:0] ch_evt;
  logic [NCH-1:0] ch_fall;
  ch_ctrl_t       ctrl_w;

  assign ctrl_w = ch_ctrl_t'(cfg_ctrl);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = cfg_we && (cfg_ch == CH_W'(g));

    dmaseq_sync #(.STAGES(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din_n (dreq_n[g]),
      .fall  (ch_fall[g])
    );

    dmaseq_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_hit   (hit),
      .cfg_ctrl  (ctrl_w),
      .cfg_count (cfg_count),
      .req_fall  (ch_fall[g]),
      .xfer_fire (ch_fire[g]),
      .bus_req   (ch_req[g]),
      .done      (done_stat[g]),
      .irq_evt   (ch_evt[g])
    );
  end

  dmaseq_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (ch_req),
    .ready  (xfer_ready),
    .valid  (xfer_valid),
    .gnt_ch (xfer_ch),
    .fire   (ch_fire)
  );

  dmaseq_irq #(.NCH(NCH), .CH_W(CH_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ch_evt),
    .clr   (irq_clr),
    .mask  (irq_mask),
    .pend  (irq_pend),
    .irq   (irq_out),
    .vec   (irq_vec)
  );
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int NCH  = 4,
  parameter int CH_W = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic            xfer_valid,
  input logic            xfer_ready,
  input logic [CH_W-1:0] xfer_ch,
  input logic [NCH-1:0]  irq_pend,
  input logic [NCH-1:0]  irq_clr,
  input logic [NCH-1:0]  irq_mask,
  input logic            irq_out,
  input logic [CH_W-1:0] irq_vec,
  input logic [NCH-1:0]  done_stat
);
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready && !cfg_we) |=> (xfer_valid && $stable(xfer_ch))); // R9

  AST_PEND_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_pend & ~$past(irq_pend)) != '0) |-> $past(xfer_valid && xfer_ready)); // R4

  AST_DONE_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_stat & ~$past(done_stat)) != '0) |-> $past(xfer_valid && xfer_ready)); // R1

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(irq_pend) & ~$past(irq_clr)) & ~irq_pend) == '0)); // R6

  AST_VEC_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((((irq_pend & irq_mask) >> irq_vec) & NCH'(1)) == NCH'(1) &&
                 ((irq_pend & irq_mask) & ((NCH'(1) << irq_vec) - NCH'(1))) == '0)); // R7

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> ((irq_pend & irq_mask) == '0)); // R7
endmodule

bind dma_seq_top dma_seq_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (.*);

// File: tb/dma_seq_top_test.sv
module dma_seq_top_test;
  localparam int NCH   = 4;
  localparam int CNT_W = 8;
  localparam int CH_W  = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [CH_W-1:0]  cfg_ch = '0;
  logic [3:0]       cfg_ctrl = '0;
  logic [CNT_W-1:0] cfg_count = '0;
  logic [NCH-1:0]   dreq_n = '1;
  logic             xfer_valid;
  logic             xfer_ready;
  logic [CH_W-1:0]  xfer_ch;
  logic [NCH-1:0]   irq_mask = '1;
  logic [NCH-1:0]   irq_clr = '0;
  logic [NCH-1:0]   irq_pend;
  logic             irq_out;
  logic [CH_W-1:0]  irq_vec;
  logic [NCH-1:0]   done_stat;

  int checks = 0;
  int errors = 0;
  int rdy_mode = 1;
  int cyc = 0;
  int model_last = NCH - 1;
  int exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign xfer_ready = (rdy_mode == 1) || (rdy_mode == 2 && (cyc % 3) != 0);

  dma_seq_top #(.NCH(NCH), .CNT_W(CNT_W)) uut (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: pops the expected grant for every accepted transfer
  always @(negedge clk) begin
    if (rst_n && xfer_valid && xfer_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8: unexpected transfer on ch %0d, expected none", xfer_ch);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(xfer_ch) != e) begin
          errors++;
          $display("FAIL R8: xfer_ch actual %0d expected %0d", xfer_ch, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg(input int ch, input logic [3:0] ctl, input int cnt);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_ch = CH_W'(ch); cfg_ctrl = ctl; cfg_count = CNT_W'(cnt);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // driver: predicts rotating grant order for the given remaining counts
  task automatic push_seq(input int rem0, input int rem1, input int rem2, input int rem3);
    int rem[NCH];
    int total;
    rem[0] = rem0; rem[1] = rem1; rem[2] = rem2; rem[3] = rem3;
    total = rem0 + rem1 + rem2 + rem3;
    for (int t = 0; t < total; t++) begin
      for (int k = 1; k <= NCH; k++) begin
        int c;
        c = (model_last + k) % NCH;
        if (rem[c] > 0) begin
          exp_q.push_back(c);
          rem[c]--;
          model_last = c;
          break;
        end
      end
    end
  endtask

  task automatic drain(input string tag);
    int n;
    n = 0;
    while ((exp_q.size() != 0 || xfer_valid) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check({tag, " drain"}, exp_q.size(), 0);
    tick(2);
  endtask

  task automatic w1c(input logic [NCH-1:0] bits);
    irq_clr = bits;
    tick(1);
    irq_clr = '0;
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset irq_pend", int'(irq_pend), 0);
    check("R7 reset irq_out", int'(irq_out), 0);
    check("R1 reset done", int'(done_stat), 0);
    check("R8 reset valid", int'(xfer_valid), 0);
    tick(1);

    // R1 and R3: immediate start, interrupt enabled
    push_seq(3, 0, 0, 0);
    cfg(0, 4'b1001, 3);
    drain("R1");
    @(negedge clk);
    check("R1 done[0]", int'(done_stat[0]), 1);
    check("R3 pend[0]", int'(irq_pend[0]), 1);
    check("R7 vec", int'(irq_vec), 0);
    check("R7 irq_out", int'(irq_out), 1);

    // R6: bit held, then cleared by W1C
    tick(5);
    @(negedge clk);
    check("R6 pend held", int'(irq_pend[0]), 1);
    w1c(4'b0001);
    @(negedge clk);
    check("R6 pend cleared", int'(irq_pend[0]), 0);

    // R4: zero count write
    cfg(1, 4'b1001, 0);
    tick(10);
    @(negedge clk);
    check("R4 no valid", int'(xfer_valid), 0);
    check("R4 pend[1]", int'(irq_pend[1]), 0);
    check("R4 done[1]", int'(done_stat[1]), 0);

    // R3: interrupt enable off
    push_seq(0, 0, 2, 0);
    cfg(2, 4'b0001, 2);
    drain("R3");
    @(negedge clk);
    check("R3 done[2]", int'(done_stat[2]), 1);
    check("R3 pend[2] off", int'(irq_pend[2]), 0);

    // R10: chaining selected, no start
    cfg(2, 4'b1011, 2);
    tick(10);
    @(negedge clk);
    check("R10 no valid", int'(xfer_valid), 0);
    check("R10 done[2]", int'(done_stat[2]), 0);

    // R2: request mode waits for falling edge
    cfg(3, 4'b1101, 2);
    tick(12);
    @(negedge clk);
    check("R2 waits while high", int'(xfer_valid), 0);
    push_seq(0, 0, 0, 2);
    dreq_n[3] = 1'b0;
    drain("R2");
    @(negedge clk);
    check("R2 done[3]", int'(done_stat[3]), 1);
    dreq_n = '1;
    w1c('1);
    tick(5);

    // R8: four channels released together under back-pressure
    for (int c = 0; c < NCH; c++) begin
      int cnts[NCH] = '{3, 1, 2, 2};
      cfg(c, 4'b1101, cnts[c]);
    end
    tick(2);
    push_seq(3, 1, 2, 2);
    rdy_mode = 2;
    dreq_n = '0;
    drain("R8");
    rdy_mode = 1;
    dreq_n = '1;
    @(negedge clk);
    check("R8 all done", int'(done_stat), 15);
    check("R7 vec all", int'(irq_vec), 0);
    irq_mask = 4'b1100;
    @(negedge clk);
    check("R7 vec masked", int'(irq_vec), 2);
    irq_mask = 4'b0000;
    @(negedge clk);
    check("R7 out masked", int'(irq_out), 0);
    irq_mask = '1;
    w1c('1);

    // R5 and R9: stall then disable
    rdy_mode = 0;
    cfg(0, 4'b1001, 5);
    @(negedge clk);
    check("R9 valid stalled", int'(xfer_valid), 1);
    check("R9 ch stalled", int'(xfer_ch), 0);
    @(negedge clk);
    check("R9 valid held", int'(xfer_valid), 1);
    check("R9 ch held", int'(xfer_ch), 0);
    cfg(0, 4'b0000, 5);
    rdy_mode = 1;
    tick(10);
    @(negedge clk);
    check("R5 no valid", int'(xfer_valid), 0);
    check("R5 pend[0]", int'(irq_pend[0]), 0);
    check("R5 done[0]", int'(done_stat[0]), 0);

    // R6: completion and clear on the same edge, set wins
    rdy_mode = 0;
    cfg(1, 4'b1001, 1);
    push_seq(0, 1, 0, 0);
    rdy_mode = 1;
    irq_clr = 4'b0010;
    tick(1);
    rdy_mode = 0;
    irq_clr = '0;
    @(negedge clk);
    check("R6 set wins", int'(irq_pend[1]), 1);
    w1c(4'b0010);
    @(negedge clk);
    check("R6 later clear", int'(irq_pend[1]), 0);
    check("R8 queue empty", exp_q.size(), 0);
    rdy_mode = 1;

    tick(2);
    finish_run();
  end
endmodule